// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit processor with one architectural delay slot fetches next. Each time the pipeline resolves an instruction it raises `step` and presents that instruction's address, a decoded transfer kind, the 16-bit branch offset, the 26-bit jump index and two register operands. The unit evaluates the branch condition and forms the target address. It also decides whether a return address must be written, and where. Finally it tracks the delay slot, so that a taken transfer only redirects fetch once the slot instruction has been resolved.

All outputs are registered and change one clock after the `step` that causes them. The address moves to `cur_pc + 4` after a transfer. The following step is treated as the delay slot, and its result is the transfer target. Branch-likely forms flag their slot for annulment when they are not taken. An unaligned register target is reported only when the slot instruction completes.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `next_pc` becomes RESET_VEC (0 by default), every strobe output (`taken`, `squash_slot`, `link_we`, `misalign_exc`) goes low, and no delay slot is pending.
- R2: A step outside a delay slot sets `next_pc` to `cur_pc + 4` one clock later. This applies to any instruction, taken or not. `taken` is high only for a taken transfer. Kind codes are 0 none, 1 equal, 2 not-equal, 3 below-zero, 4 at-or-below-zero, 5 above-zero, 6 at-or-above-zero, 7 below-zero-and-link, 8 at-or-above-zero-and-link, 9 jump, 10 jump-and-link, 11 register jump, 12 register jump-and-link. Codes 13 to 15 act as 0.
- R3: Branch conditions compare `opnd_a` with `opnd_b` (kinds 1 and 2) or with zero (kinds 3 to 8) as signed 32-bit integers.
- R4: The step after a transfer is its delay slot. If the transfer was taken, that step sets `next_pc` to the stored target. Otherwise it sets `next_pc` to `cur_pc + 4`.
- R5: The branch target is `cur_pc + 4` plus the offset shifted left by two and sign-extended from 18 bits.
- R6: The absolute jump target is the 26-bit index shifted left by two, placed under bits 31..28 of `cur_pc + 4`.
- R7: Linking kinds (7, 8, 10, 12) raise `link_we` with `link_addr = cur_pc + 8`, whether taken or not. Kinds 7, 8 and 10 write register 31. Kind 12 writes the register `link_rd`, and requests no write when `link_rd` is 0.
- R8: Register jumps target `opnd_a`. If bits 1..0 of `opnd_a` are not zero, `misalign_exc` pulses with the delay-slot step's result and not with the jump's.
- R9: With `likely` high, an untaken conditional branch raises `squash_slot`. A taken one does not. `likely` has no effect on other kinds.
- R10: Inside a delay slot the transfer kind is ignored: no link, no `taken`, and no new target.
- R11: A cycle without `step` keeps `next_pc` and clears all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Resolve the instruction presented this cycle |
| cur_pc | input | 32 | Address of that instruction |
| xfer_kind | input | 4 | Decoded transfer kind |
| likely | input | 1 | Branch-likely form |
| br_offset | input | 16 | Branch word offset |
| jmp_index | input | 26 | Absolute jump word index |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| link_rd | input | 5 | Destination for register jump-and-link |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | Resolved instruction was a taken transfer |
| squash_slot | output | 1 | Annul the delay slot |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Return-address destination |
| link_addr | output | 32 | Return address |
| misalign_exc | output | 1 | Unaligned register target trap |

## Verification
A wrong internal state here is nearly always a lost or stale delay-slot record. It shows at the ports exactly one step late. Either the slot step redirects when it should fall through, or a transfer sitting in a slot steers fetch. A stored target that is corrupt appears in `next_pc` at the slot step, and a stale misalignment record shows as a stray `misalign_exc`. The scenarios therefore always pair a transfer with its slot step and compare both results.

// File: rtl/npc_pkg.sv
// Shared types for the next-PC unit.
// Assumes the kind encoding listed in the block requirements.
package npc_pkg;

    typedef enum logic [3:0] {
        XK_NONE      = 4'd0,
        XK_EQ        = 4'd1,
        XK_NE        = 4'd2,
        XK_LTZ       = 4'd3,
        XK_LEZ       = 4'd4,
        XK_GTZ       = 4'd5,
        XK_GEZ       = 4'd6,
        XK_LTZ_LINK  = 4'd7,
        XK_GEZ_LINK  = 4'd8,
        XK_JUMP      = 4'd9,
        XK_JUMP_LINK = 4'd10,
        XK_JREG      = 4'd11,
        XK_JREG_LINK = 4'd12
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_LTZ = 3'd2,
        CC_LEZ = 3'd3,
        CC_GTZ = 3'd4,
        CC_GEZ = 3'd5
    } cond_e;

    typedef struct packed {
        logic  is_branch;  // conditional, PC-relative
        logic  is_jabs;    // absolute region jump
        logic  is_jreg;    // register-indirect jump
        logic  do_link;    // writes a return address
        logic  link_any;   // destination comes from link_rd
        cond_e cond;
    } xfer_dec_t;

endpackage

// File: rtl/npc_decode.sv
// Turns the transfer kind code into control flags.
// Assumes unknown codes behave as no transfer.
module npc_decode
    import npc_pkg::*;
(
    input  logic [3:0] kind,
    output xfer_dec_t  dec
);

    // Per-kind flag table
    always_comb begin
        dec = '{is_branch: 1'b0, is_jabs: 1'b0, is_jreg: 1'b0,
                do_link: 1'b0, link_any: 1'b0, cond: CC_EQ};
        case (xfer_kind_e'(kind))
            XK_EQ:        begin dec.is_branch = 1'b1; dec.cond = CC_EQ;  end
            XK_NE:        begin dec.is_branch = 1'b1; dec.cond = CC_NE;  end
            XK_LTZ:       begin dec.is_branch = 1'b1; dec.cond = CC_LTZ; end
            XK_LEZ:       begin dec.is_branch = 1'b1; dec.cond = CC_LEZ; end
            XK_GTZ:       begin dec.is_branch = 1'b1; dec.cond = CC_GTZ; end
            XK_GEZ:       begin dec.is_branch = 1'b1; dec.cond = CC_GEZ; end
            XK_LTZ_LINK:  begin dec.is_branch = 1'b1; dec.cond = CC_LTZ; dec.do_link = 1'b1; end
            XK_GEZ_LINK:  begin dec.is_branch = 1'b1; dec.cond = CC_GEZ; dec.do_link = 1'b1; end
            XK_JUMP:      dec.is_jabs = 1'b1;
            XK_JUMP_LINK: begin dec.is_jabs = 1'b1; dec.do_link = 1'b1; end
            XK_JREG:      dec.is_jreg = 1'b1;
            XK_JREG_LINK: begin dec.is_jreg = 1'b1; dec.do_link = 1'b1; dec.link_any = 1'b1; end
            default:      ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
// Signed branch condition evaluation.
// Assumes operands are two's complement of width XLEN.
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e            cond,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic             hit
);

    logic a_neg, a_zero, ab_eq;

    // Shared sign/zero/equality terms
    always_comb begin
        a_neg  = a[XLEN-1];
        a_zero = (a == '0);
        ab_eq  = (a == b);
    end

    // Condition select
    always_comb begin
        case (cond)
            CC_EQ:   hit = ab_eq;
            CC_NE:   hit = !ab_eq;
            CC_LTZ:  hit = a_neg;
            CC_LEZ:  hit = a_neg || a_zero;
            CC_GTZ:  hit = !a_neg && !a_zero;
            CC_GEZ:  hit = !a_neg;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Target and return address arithmetic.
// Assumes word-addressed instructions (two zero low bits on PC-derived targets).
module npc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] index,
    input  logic [XLEN-1:0]  reg_val,
    output logic [XLEN-1:0]  slot_pc,
    output logic [XLEN-1:0]  ret_pc,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jabs_tgt,
    output logic             reg_misaligned
);

    localparam int DISP_W = OFF_W + 2;
    localparam int EXT_W  = XLEN - DISP_W;
    localparam int REGN_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] disp;

    // Sequential addresses
    always_comb begin
        slot_pc = pc + XLEN'(4);
        ret_pc  = pc + XLEN'(8);
    end

    // Branch displacement and target
    always_comb begin
        disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        br_tgt = slot_pc + disp;
    end

    // Absolute region jump, region taken from the slot address
    always_comb begin
        jabs_tgt = {slot_pc[XLEN-1 -: REGN_W], index, 2'b00};
    end

    // Word alignment of a register target
    always_comb begin
        reg_misaligned = |reg_val[1:0];
    end

endmodule

// File: rtl/npc_unit.sv
// Next-PC unit with one delay slot.
// Assumes the caller raises step once per resolved instruction, in program
// order, and presents the slot instruction on the step after a transfer.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              OFF_W     = 16,
    parameter int              IDX_W     = 26,
    parameter int              REG_W     = 5,
    parameter int              RA_REG    = 31,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [3:0]       xfer_kind,
    input  logic             likely,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [IDX_W-1:0] jmp_index,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [REG_W-1:0] link_rd,
    output logic [XLEN-1:0]  next_pc,
    output logic             taken,
    output logic             squash_slot,
    output logic             link_we,
    output logic [REG_W-1:0] link_reg,
    output logic [XLEN-1:0]  link_addr,
    output logic             misalign_exc
);

    localparam logic [REG_W-1:0] RA_IDX = REG_W'(RA_REG);

    xfer_dec_t       dec;
    logic            cond_hit;
    logic [XLEN-1:0] slot_pc, ret_pc, br_tgt, jabs_tgt;
    logic            reg_mis;

    logic            is_xfer, take;
    logic [XLEN-1:0] tgt_sel;
    logic [REG_W-1:0] dst_sel;
    logic            dst_ok;

    logic            slot_q;       // next step is a delay slot
    logic            redir_q;      // that slot ends in a redirect
    logic [XLEN-1:0] tgt_q;
    logic            mis_q;
    logic            pend_redirect;

    npc_decode u_dec (
        .kind (xfer_kind),
        .dec  (dec)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .cond (dec.cond),
        .a    (opnd_a),
        .b    (opnd_b),
        .hit  (cond_hit)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .pc             (cur_pc),
        .offset         (br_offset),
        .index          (jmp_index),
        .reg_val        (opnd_a),
        .slot_pc        (slot_pc),
        .ret_pc         (ret_pc),
        .br_tgt         (br_tgt),
        .jabs_tgt       (jabs_tgt),
        .reg_misaligned (reg_mis)
    );

    // Outcome and target choice for a transfer outside a slot
    always_comb begin
        is_xfer = dec.is_branch || dec.is_jabs || dec.is_jreg;
        take    = dec.is_branch ? cond_hit : (dec.is_jabs || dec.is_jreg);
        if (dec.is_jreg)      tgt_sel = opnd_a;
        else if (dec.is_jabs) tgt_sel = jabs_tgt;
        else                  tgt_sel = br_tgt;
    end

    // Link destination choice
    always_comb begin
        dst_sel = dec.link_any ? link_rd : RA_IDX;
        dst_ok  = dec.do_link && (dst_sel != '0);
    end

    // Delay-slot record and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc      <= RESET_VEC;
            taken        <= 1'b0;
            squash_slot  <= 1'b0;
            link_we      <= 1'b0;
            link_reg     <= '0;
            link_addr    <= '0;
            misalign_exc <= 1'b0;
            slot_q       <= 1'b0;
            redir_q      <= 1'b0;
            tgt_q        <= '0;
            mis_q        <= 1'b0;
        end else if (!step) begin
            taken        <= 1'b0;
            squash_slot  <= 1'b0;
            link_we      <= 1'b0;
            misalign_exc <= 1'b0;
        end else if (slot_q) begin
            next_pc      <= redir_q ? tgt_q : slot_pc;
            misalign_exc <= redir_q && mis_q;
            taken        <= 1'b0;
            squash_slot  <= 1'b0;
            link_we      <= 1'b0;
            slot_q       <= 1'b0;
            redir_q      <= 1'b0;
            mis_q        <= 1'b0;
        end else begin
            next_pc      <= slot_pc;
            misalign_exc <= 1'b0;
            taken        <= is_xfer && take;
            squash_slot  <= dec.is_branch && likely && !cond_hit;
            link_we      <= dst_ok;
            link_reg     <= dst_sel;
            link_addr    <= ret_pc;
            slot_q       <= is_xfer;
            redir_q      <= is_xfer && take;
            tgt_q        <= tgt_sel;
            mis_q        <= dec.is_jreg && reg_mis;
        end
    end

    // Redirect pending for the coming slot step
    always_comb begin
        pend_redirect = slot_q && redir_q;
    end

endmodule

// File: rtl/npc_unit_chk.sv
// Temporal checks on the next-PC unit, attached by bind.
module npc_unit_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic [XLEN-1:0]  cur_pc,
    input logic             in_slot,
    input logic             pend_redirect,
    input logic [XLEN-1:0]  pend_target,
    input logic [XLEN-1:0]  next_pc,
    input logic             taken,
    input logic             squash_slot,
    input logic             link_we,
    input logic [REG_W-1:0] link_reg,
    input logic             misalign_exc
);

    // R2: a step outside a slot advances by one word
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !in_slot) |=> (next_pc == $past(cur_pc) + XLEN'(4)));

    // R4: the slot step lands on the stored target
    assert_slot_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pend_redirect) |=> (next_pc == $past(pend_target)));

    // R10: a transfer inside a slot produces no transfer strobes
    assert_slot_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_slot) |=> (!taken && !link_we && !squash_slot));

    // R11: idle cycles hold the address and clear strobes
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(next_pc) && !taken && !squash_slot && !link_we && !misalign_exc));

    // R8: the trap never coincides with the transfer itself
    assert_trap_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_exc |-> !taken);

    // R9: annulment only for untaken branches
    assert_squash_untaken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_slot |-> !taken);

    // R7: no write request to the zero register
    assert_link_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_reg != '0));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_npc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step),
    .cur_pc        (cur_pc),
    .in_slot       (slot_q),
    .pend_redirect (pend_redirect),
    .pend_target   (tgt_q),
    .next_pc       (next_pc),
    .taken         (taken),
    .squash_slot   (squash_slot),
    .link_we       (link_we),
    .link_reg      (link_reg),
    .misalign_exc  (misalign_exc)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [3:0]  xfer_kind = '0;
    logic        likely = 1'b0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_index = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  link_rd = '0;
    logic [31:0] next_pc;
    logic        taken, squash_slot, link_we, misalign_exc;
    logic [4:0]  link_reg;
    logic [31:0] link_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .step(step), .cur_pc(cur_pc),
        .xfer_kind(xfer_kind), .likely(likely), .br_offset(br_offset),
        .jmp_index(jmp_index), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .link_rd(link_rd), .next_pc(next_pc), .taken(taken),
        .squash_slot(squash_slot), .link_we(link_we), .link_reg(link_reg),
        .link_addr(link_addr), .misalign_exc(misalign_exc)
    );

    typedef struct {
        logic [31:0] pc;
        logic        tk;
        logic        sq;
        logic        lwe;
        logic [4:0]  lreg;
        logic [31:0] laddr;
        logic        exc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Spec-level model state
    logic        m_slot = 1'b0;
    logic        m_redir = 1'b0;
    logic [31:0] m_tgt = '0;
    logic        m_mis = 1'b0;
    logic [31:0] last_pc = '0;
    logic        stepped = 1'b0;
    logic        mon_on = 1'b0;

    task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    endtask

    // Driver: compute the expectation, push it, present the step
    task automatic issue(input logic [31:0] pc, input int kind, input logic lk,
                         input logic [15:0] off, input logic [25:0] idx,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] rd, input string tag);
        exp_t e;
        logic br, ja, jr, lnk, c, tk;
        logic [31:0] tgt;
        logic [4:0] dst;
        e = '{pc: pc + 32'd4, tk: 0, sq: 0, lwe: 0, lreg: 0, laddr: 0, exc: 0, tag: tag};
        if (m_slot) begin
            e.pc  = m_redir ? m_tgt : pc + 32'd4;
            e.exc = m_redir && m_mis;
            m_slot = 0; m_redir = 0; m_mis = 0;
        end else begin
            br  = (kind >= 1 && kind <= 8);
            ja  = (kind == 9 || kind == 10);
            jr  = (kind == 11 || kind == 12);
            lnk = (kind == 7 || kind == 8 || kind == 10 || kind == 12);
            case (kind)
                1: c = (a == b);
                2: c = (a != b);
                3, 7: c = ($signed(a) < 0);
                4: c = ($signed(a) <= 0);
                5: c = ($signed(a) > 0);
                6, 8: c = ($signed(a) >= 0);
                default: c = 0;
            endcase
            tk = br ? c : (ja || jr);
            if (jr)      tgt = a;
            else if (ja) tgt = {pc[31:28] + 4'd0, idx, 2'b00} | ((pc + 32'd4) & 32'hF000_0000);
            else         tgt = pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
            if (ja) tgt = {((pc + 32'd4) >> 28), idx, 2'b00};
            dst = (kind == 12) ? rd : 5'd31;
            e.tk    = (br || ja || jr) && tk;
            e.sq    = br && lk && !c;
            e.lwe   = lnk && (dst != 0);
            e.lreg  = dst;
            e.laddr = pc + 32'd8;
            m_slot  = br || ja || jr;
            m_redir = e.tk;
            m_tgt   = tgt;
            m_mis   = jr && (a[1:0] != 2'b00);
        end
        @(negedge clk);
        cur_pc = pc; xfer_kind = 4'(kind); likely = lk; br_offset = off;
        jmp_index = idx; opnd_a = a; opnd_b = b; link_rd = rd; step = 1'b1;
        exp_q.push_back(e);
        @(posedge clk);
        #1 step = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    always @(posedge clk) stepped <= step && rst_n;

    // Monitor: compare one item per completed step, idle checks otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            if (stepped) begin
                exp_t e;
                logic bad;
                if (exp_q.size() == 0) begin
                    n_tests++;
                    fail_line("R2", "unexpected step result", next_pc, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    n_tests++;
                    bad = 0;
                    if (next_pc !== e.pc) begin fail_line(e.tag, "next_pc", next_pc, e.pc); bad = 1; end
                    if (taken !== e.tk) begin fail_line(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk}); bad = 1; end
                    if (squash_slot !== e.sq) begin fail_line(e.tag, "squash_slot", {31'd0, squash_slot}, {31'd0, e.sq}); bad = 1; end
                    if (link_we !== e.lwe) begin fail_line(e.tag, "link_we", {31'd0, link_we}, {31'd0, e.lwe}); bad = 1; end
                    if (e.lwe && link_reg !== e.lreg) begin fail_line(e.tag, "link_reg", {27'd0, link_reg}, {27'd0, e.lreg}); bad = 1; end
                    if (e.lwe && link_addr !== e.laddr) begin fail_line(e.tag, "link_addr", link_addr, e.laddr); bad = 1; end
                    if (misalign_exc !== e.exc) begin fail_line(e.tag, "misalign_exc", {31'd0, misalign_exc}, {31'd0, e.exc}); bad = 1; end
                    if (bad) n_fail += 0;
                    last_pc = e.pc;
                end
            end else begin
                // R11: idle cycle holds address, strobes low
                n_tests++;
                if (next_pc !== last_pc || taken || squash_slot || link_we || misalign_exc)
                    fail_line("R11", "idle hold next_pc", next_pc, last_pc);
            end
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step = 1'b1;      // must be ignored under reset
        cur_pc = 32'h1234_5678;
        xfer_kind = 4'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if (next_pc !== 32'h0 || taken || squash_slot || link_we || misalign_exc)
            fail_line("R1", "reset next_pc", next_pc, 32'h0);
        step = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R2: plain and unknown-kind steps
        issue(32'h0000_0100, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R2");
        issue(32'h0000_0104, 14, 0, 16'h0010, 26'h0, 0, 0, 0, "R2");
        idle(2);

        // R3 R5: equal taken, forward offset, then its slot (R4)
        issue(32'h0000_0200, 1, 0, 16'h0010, 26'h0, 32'd5, 32'd5, 0, "R5");
        issue(32'h0000_0204, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R4");
        // R3: not-equal with equal operands is untaken
        issue(32'h0000_0300, 2, 0, 16'h0010, 26'h0, 32'd7, 32'd7, 0, "R3");
        issue(32'h0000_0304, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R4");
        // R5: negative offset, at-or-above-zero with zero operand
        issue(32'h0000_0400, 6, 0, 16'hFFFE, 26'h0, 32'h0, 0, 0, "R5");
        issue(32'h0000_0404, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R5");
        // R3: signed compares
        issue(32'h0000_0500, 3, 0, 16'h0004, 26'h0, 32'h8000_0000, 0, 0, "R3");
        issue(32'h0000_0504, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3");
        issue(32'h0000_0600, 5, 0, 16'h0004, 26'h0, 32'h8000_0000, 0, 0, "R3");
        issue(32'h0000_0604, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3");
        issue(32'h0000_0700, 4, 0, 16'h0004, 26'h0, 32'h0, 0, 0, "R3");
        issue(32'h0000_0704, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3");
        issue(32'h0000_0800, 5, 0, 16'h0004, 26'h0, 32'h1, 0, 0, "R3");
        issue(32'h0000_0804, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R3");
        // R6: jump whose slot crosses the region boundary
        issue(32'h0FFF_FFFC, 9, 0, 16'h0, 26'h10, 0, 0, 0, "R6");
        issue(32'h1000_0000, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R6");
        // R7: jump-and-link to register 31
        issue(32'h2000_0010, 10, 0, 16'h0, 26'h0_0040, 0, 0, 0, "R7");
        issue(32'h2000_0014, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R7");
        // R7: untaken below-zero-and-link still links
        issue(32'h0000_0900, 7, 0, 16'h0008, 26'h0, 32'd3, 0, 0, "R7");
        issue(32'h0000_0904, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R7");
        // R7 R8: register jump-and-link to register 7
        issue(32'h0000_0A00, 12, 0, 16'h0, 26'h0, 32'h0000_3000, 0, 5'd7, "R7");
        issue(32'h0000_0A04, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R8");
        // R7: register jump-and-link naming register 0 requests no write
        issue(32'h0000_3000, 12, 0, 16'h0, 26'h0, 32'h0000_3100, 0, 5'd0, "R7");
        issue(32'h0000_3004, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R8");
        // R8: misaligned register target traps at the slot step
        issue(32'h0000_3100, 11, 0, 16'h0, 26'h0, 32'h0000_2002, 0, 0, "R8");
        issue(32'h0000_3104, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R8");
        idle(1);
        // R9: likely untaken squashes, likely taken does not
        issue(32'h0000_4000, 1, 1, 16'h0020, 26'h0, 32'd1, 32'd2, 0, "R9");
        issue(32'h0000_4004, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R9");
        issue(32'h0000_4100, 1, 1, 16'h0020, 26'h0, 32'd2, 32'd2, 0, "R9");
        issue(32'h0000_4104, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R9");
        // R9: likely has no effect on a jump
        issue(32'h0000_4200, 9, 1, 16'h0, 26'h0_1000, 0, 0, 0, "R9");
        issue(32'h0000_4204, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R9");
        // R10: a transfer in the slot is ignored
        issue(32'h0000_5000, 1, 0, 16'h0040, 26'h0, 32'd9, 32'd9, 0, "R10");
        issue(32'h0000_5004, 10, 0, 16'h0, 26'h0_0777, 0, 0, 0, "R10");
        issue(32'h0000_5104, 0, 0, 16'h0, 26'h0, 0, 0, 0, "R2");
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule